// File: doc/BRIEF.md
# Add/Subtract Status Flag Generator

This combinational block sits beside an integer adder/subtractor. It takes two operands, an add/subtract select, an operand size select and a carry-in. It returns the sum or difference, truncated to the selected size. Alongside the result it produces an image of the arithmetic status flags for that operation, ready to be merged into the flags register by the surrounding datapath.

The six flags are carry, overflow, sign, zero, nibble carry and low-byte parity. Each one is taken from the bit or carry that belongs to the selected operand size. The exceptions are the nibble carry, which always comes from bit 3 into bit 4, and the parity, which always covers only the lowest result byte. Storage of the flags and all non-arithmetic flags are left to the surrounding logic.

Top module: `flg_status_gen`

## Requirements
- R1: `size_i` selects the operand size: 2'b00 is 8 bits, 2'b01 is 16 bits, and 2'b10 or 2'b11 is the full 32 bits. `result_o` is a+b+carry (add) or a-b-carry (subtract) modulo 2^size.
- R2: For the 8- and 16-bit sizes, `result_o` bits above the size are zero, and operand bits above the size have no effect on the result or on any flag.
- R3: For addition, the carry flag at image bit 0 is the carry out of the top bit of the selected size.
- R4: For subtraction, the carry flag at image bit 0 is set exactly when the unsigned minuend is smaller than the subtrahend plus the carry-in (a borrow).
- R5: The overflow flag at image bit 11 is set when the signed result is outside the signed range of the selected size.
- R6: The sign flag at image bit 7 equals the top bit of the result at the selected size.
- R7: The zero flag at image bit 6 is set when all result bits at the selected size are zero.
- R8: The nibble carry flag at image bit 4 is the carry (add) or borrow (subtract) from bit 3 into bit 4, whatever the size.
- R9: The parity flag at image bit 2 is set when result bits 7:0 hold an even number of ones, whatever the size.
- R10: Every bit of `flags_o` other than bits 0, 2, 4, 6, 7 and 11 is zero.
- R11: `op_i`=0 selects addition and `op_i`=1 selects subtraction. `carry_i` is added as a carry-in for addition and subtracted as a borrow-in for subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand (minuend for subtraction) |
| b_i | input | 32 | Second operand (subtrahend for subtraction) |
| op_i | input | 1 | 0 = add, 1 = subtract |
| size_i | input | 2 | Operand size select |
| carry_i | input | 1 | Carry-in / borrow-in |
| result_o | output | 32 | Sized, zero-extended result |
| flags_o | output | 32 | Flag image |

## Verification
The bench builds the block with its default 32-bit word width. With that width, the byte and half-word views fall at 8 and 16 bits, so the carry and overflow sources at bits 7, 15 and 31 can each be reached. Directed vectors cover several boundaries: the wrap from all-ones to zero, the crossing from the largest positive value to the most negative one, borrows with and without a borrow-in, and noise in the operand bits above the selected size. A stream of pseudo-random operands across all four size codes then exercises the flag combinations that no directed vector hits.

// File: rtl/flg_pkg.sv
package flg_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } size_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    // Positions in the flag image
    localparam int unsigned POS_CARRY  = 0;
    localparam int unsigned POS_PARITY = 2;
    localparam int unsigned POS_NIBBLE = 4;
    localparam int unsigned POS_ZERO   = 6;
    localparam int unsigned POS_SIGN   = 7;
    localparam int unsigned POS_OVFL   = 11;
    localparam int unsigned IMG_W      = 32;

    typedef struct packed {
        logic ovfl;
        logic sign;
        logic zero;
        logic nibble;
        logic parity;
        logic carry;
    } flags_t;

    // Raw per-size view of the adder
    typedef struct packed {
        logic msb;
        logic c_top_in;
        logic c_top_out;
    } view_t;

    function automatic logic even_ones(input logic [7:0] v);
        return ~^v;
    endfunction

    function automatic int unsigned size_index(input size_e s);
        case (s)
            SZ_BYTE: return 0;
            SZ_HALF: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/flg_addsub.sv
module flg_addsub
    import flg_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic [W:0]   carries   // carries[i] = carry into bit i
);

    logic [W-1:0] b_eff;
    logic         is_sub;

    assign is_sub     = (op == OP_SUB);
    assign b_eff      = is_sub ? ~b : b;
    assign carries[0] = is_sub ? ~cin : cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p_i;
        assign p_i            = a[i] ^ b_eff[i];
        assign sum[i]         = p_i ^ carries[i];
        assign carries[i + 1] = (a[i] & b_eff[i]) | (p_i & carries[i]);
    end

endmodule

// File: rtl/flg_size_view.sv
module flg_size_view
    import flg_pkg::*;
#(
    parameter int unsigned W = WORD_W
) (
    input  logic [W-1:0] sum,
    input  logic [W:0]   carries,
    input  size_e        size,
    input  op_e          op,
    output logic [W-1:0] result,
    output flags_t       flags
);

    localparam int unsigned NUM_SZ = 3;
    localparam int unsigned BYTE_W = W / 4;
    localparam int unsigned HALF_W = W / 2;

    logic [W-1:0] cand_res  [NUM_SZ];
    view_t        cand_view [NUM_SZ];
    view_t        view;
    logic         is_sub;

    for (genvar k = 0; k < NUM_SZ; k++) begin : g_size
        localparam int unsigned LW = (k == 0) ? BYTE_W : (k == 1) ? HALF_W : W;
        localparam logic [W-1:0] MASK = {W{1'b1}} >> (W - LW);
        assign cand_res[k]            = sum & MASK;
        assign cand_view[k].msb       = sum[LW-1];
        assign cand_view[k].c_top_in  = carries[LW-1];
        assign cand_view[k].c_top_out = carries[LW];
    end

    assign is_sub = (op == OP_SUB);

    always_comb begin
        result = cand_res[size_index(size)];
        view   = cand_view[size_index(size)];
        flags.carry  = view.c_top_out ^ is_sub;
        flags.ovfl   = view.c_top_in ^ view.c_top_out;
        flags.sign   = view.msb;
        flags.zero   = (result == '0);
        flags.nibble = carries[4] ^ is_sub;
        flags.parity = even_ones(result[7:0]);
    end

endmodule

// File: rtl/flg_pack.sv
module flg_pack
    import flg_pkg::*;
(
    input  flags_t             flags,
    output logic [IMG_W-1:0]   image
);

    always_comb begin
        image             = '0;
        image[POS_CARRY]  = flags.carry;
        image[POS_PARITY] = flags.parity;
        image[POS_NIBBLE] = flags.nibble;
        image[POS_ZERO]   = flags.zero;
        image[POS_SIGN]   = flags.sign;
        image[POS_OVFL]   = flags.ovfl;
    end

endmodule

// File: rtl/flg_status_gen.sv
module flg_status_gen
    import flg_pkg::*;
#(
    parameter int unsigned WIDTH = WORD_W
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             op_i,
    input  logic [1:0]       size_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic [IMG_W-1:0] flags_o
);

    localparam int unsigned BYTE_W = WIDTH / 4;
    localparam int unsigned HALF_W = WIDTH / 2;
    localparam logic [IMG_W-1:0] USED_BITS =
        (IMG_W'(1) << POS_CARRY)  | (IMG_W'(1) << POS_PARITY) |
        (IMG_W'(1) << POS_NIBBLE) | (IMG_W'(1) << POS_ZERO)   |
        (IMG_W'(1) << POS_SIGN)   | (IMG_W'(1) << POS_OVFL);

    op_e            op;
    size_e          size;
    logic [WIDTH-1:0] sum;
    logic [WIDTH:0]   carries;
    flags_t           flags;

    assign op   = op_e'(op_i);
    assign size = size_e'(size_i);

    flg_addsub #(.W(WIDTH)) u_addsub (
        .a       (a_i),
        .b       (b_i),
        .op      (op),
        .cin     (carry_i),
        .sum     (sum),
        .carries (carries)
    );

    flg_size_view #(.W(WIDTH)) u_view (
        .sum     (sum),
        .carries (carries),
        .size    (size),
        .op      (op),
        .result  (result_o),
        .flags   (flags)
    );

    flg_pack u_pack (
        .flags (flags),
        .image (flags_o)
    );

    always_comb begin
        // R10
        img_rsvd_chk: assert ((flags_o & ~USED_BITS) == '0);
        // R7
        zero_flag_chk: assert (flags_o[POS_ZERO] == (result_o == '0));
        // R9
        parity_flag_chk: assert (flags_o[POS_PARITY] == ~^result_o[7:0]);
        // R2
        upper_zero_chk: assert (
            (size == SZ_BYTE) ? (result_o >> BYTE_W) == '0 :
            (size == SZ_HALF) ? (result_o >> HALF_W) == '0 : 1'b1);
        // R6
        sign_flag_chk: assert (flags_o[POS_SIGN] ==
            ((size == SZ_BYTE) ? result_o[BYTE_W-1] :
             (size == SZ_HALF) ? result_o[HALF_W-1] : result_o[WIDTH-1]));
    end

endmodule

// File: tb/tb_flg_status_gen.sv
module tb_flg_status_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct {
        logic [31:0] res;
        logic [31:0] img;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        op_i = 1'b0;
    logic [1:0]  size_i = 2'b10;
    logic        carry_i = 1'b0;
    logic [31:0] result_o;
    logic [31:0] flags_o;

    item_t exp_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    summary_done = 0;

    flg_status_gen dut (
        .a_i      (a_i),
        .b_i      (b_i),
        .op_i     (op_i),
        .size_i   (size_i),
        .carry_i  (carry_i),
        .result_o (result_o),
        .flags_o  (flags_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic op,
                         input logic [1:0] sz, input logic cin,
                         output logic [31:0] res, output logic [31:0] img);
        int w;
        longint unsigned m, ua, ub, full, r;
        longint sa, sb, sr, lim;
        logic cf, of, sf, zf, af, pf;
        w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m  = (64'd1 << w) - 1;
        ua = {32'd0, a} & m;
        ub = {32'd0, b} & m;
        lim = longint'(64'd1 << (w - 1));
        sa = ((ua >> (w - 1)) & 1) != 0 ? longint'(ua) - 2 * lim : longint'(ua);
        sb = ((ub >> (w - 1)) & 1) != 0 ? longint'(ub) - 2 * lim : longint'(ub);
        if (!op) begin
            full = ua + ub + cin;
            cf   = ((full >> w) & 1) != 0;
            sr   = sa + sb + cin;
            af   = ((ua & 15) + (ub & 15) + cin) > 15;
        end else begin
            full = ua - ub - cin;
            cf   = ua < (ub + cin);
            sr   = sa - sb - cin;
            af   = (ua & 15) < ((ub & 15) + cin);
        end
        r  = full & m;
        of = (sr >= lim) || (sr < -lim);
        sf = ((r >> (w - 1)) & 1) != 0;
        zf = (r == 0);
        pf = ~^r[7:0];
        res = r[31:0];
        img = '0;
        img[0] = cf; img[2] = pf; img[4] = af;
        img[6] = zf; img[7] = sf; img[11] = of;
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b, input logic op,
                        input logic [1:0] sz, input logic cin, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        a_i = a; b_i = b; op_i = op; size_i = sz; carry_i = cin;
        model(a, b, op, sz, cin, it.res, it.img);
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic print_summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // Monitor: compare half a period after each drive
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (result_o !== e.res || flags_o !== e.img) begin
                n_bad++;
                $display("FAIL %s: result %h flags %h, expected result %h flags %h",
                         e.tag, result_o, flags_o, e.res, e.img);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: cycles %0d, expected at most %0d", cycles, WATCHDOG);
            print_summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle operands: zero result (R7, R9)
        send(32'h0, 32'h0, 1'b0, 2'b10, 1'b0, "R7 idle zero");
        // R3: byte wrap to zero
        send(32'h0000_00FF, 32'h1, 1'b0, 2'b00, 1'b0, "R3 byte carry out");
        // R5: byte signed overflow
        send(32'h7F, 32'h1, 1'b0, 2'b00, 1'b0, "R5 byte add overflow");
        // R4: half borrow
        send(32'h0, 32'h1, 1'b1, 2'b01, 1'b0, "R4 half borrow");
        // R5: word subtract overflow
        send(32'h8000_0000, 32'h1, 1'b1, 2'b10, 1'b0, "R5 word sub overflow");
        // R2: noise above byte size
        send(32'hABCD_1203, 32'hFFFF_0004, 1'b0, 2'b00, 1'b0, "R2 upper operand bits ignored");
        send(32'h1234_5680, 32'h8765_0080, 1'b0, 2'b01, 1'b0, "R2 half upper ignored");
        // R11: carry-in and borrow-in
        send(32'hFFFF_FFFF, 32'h0, 1'b0, 2'b10, 1'b1, "R11 carry-in add");
        send(32'h5, 32'h5, 1'b1, 2'b00, 1'b1, "R11 borrow-in sub");
        // R1: size code 11 acts as full word
        send(32'h0001_0000, 32'h0, 1'b0, 2'b11, 1'b0, "R1 alt word size");
        send(32'h1234_5678, 32'h1111_1111, 1'b0, 2'b10, 1'b0, "R1 word add");
        // R8: nibble carry only
        send(32'h08, 32'h08, 1'b0, 2'b00, 1'b0, "R8 nibble carry");
        send(32'h10, 32'h01, 1'b1, 2'b00, 1'b0, "R8 nibble borrow");
        // R6: half sign with overflow
        send(32'h4000, 32'h4000, 1'b0, 2'b01, 1'b0, "R6 half sign");
        // R9: parity at word size uses low byte only
        send(32'h0000_0003, 32'h0, 1'b0, 2'b10, 1'b0, "R9 parity even");
        send(32'h0100_0001, 32'h0, 1'b0, 2'b10, 1'b0, "R9 parity odd low byte");
        // R3: word carry without zero
        send(32'hFFFF_FFF0, 32'h0000_0020, 1'b0, 2'b10, 1'b0, "R3 word carry out");
        // R10 plus all others: pseudo-random sweep
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 4 == 0) ra = ra | 32'h8080_8080;
            if (i % 5 == 0) rb = ~ra;
            send(ra, rb, 1'($urandom), 2'($urandom), 1'($urandom), "R10 random sweep");
        end
        repeat (3) @(posedge clk);
        print_summary();
        $finish;
    end

endmodule